// File: doc/BRIEF.md
# Reset Source Controller with Clock-Loss Detection

This block merges every reset cause on the chip into a single active-low system reset and records which cause fired last. There are four causes: the power-on input, an active-low external reset pin, the output of a supply-threshold comparator, and a detector that notices when the system clock stops toggling. The controller runs on a free-running reference clock. The pin and the comparator are brought in through two-flop synchronizers. The system clock is sampled in the same way, and a counter measures how long it has gone without an edge.

Software reaches two 8-bit registers through a small synchronous port. The read data is combinational and a write takes effect on the next reference edge. Address 0 is the monitor register. Its bit 7 is the comparator enable (read/write), its bit 6 shows the live supply status, and its bits 5:0 read 0. Address 1 is the cause register. Its bit 0 is the pin flag, bit 1 the power-on flag, bit 2 the clock-loss flag, bit 3 the comparator-select bit and bit 4 the supply flag. Bits 7:5 read 0. Writing bit 2 of the cause register turns the clock-loss detector on or off. Writing bit 3 arms the comparator as a reset cause. All other written bits are ignored.

Every reset is stretched so that the system reset stays low for at least STRETCH_CYCLES reference cycles after its cause goes away.

Top module: `reset_src_ctrl`

## Requirements
- R1: While porN is low, sysRstN is low. After porN rises, sysRstN rises on the 8th reference edge. The cause register then reads 0x0A (power-on flag and comparator select) and the monitor enable reads 1.
- R2: At address 0, bit 7 is a read/write enable. Bit 6 follows supplyOk through two reference flops (1 = above threshold). Bits 5:0 read 0 whatever is written.
- R3: A low supplyOk resets the chip only when the enable (address 0 bit 7) and the select (address 1 bit 3) are both 1. Such a reset sets the supply flag (address 1 bit 4).
- R4: A low level on extRstN drives sysRstN low after the 3rd reference edge. sysRstN rises on the 10th edge after the pin returns high. The pin flag (address 1 bit 0) is then 1.
- R5: Each reset leaves exactly one cause flag set and clears the others. When causes coincide, the priority is pin, then supply, then clock loss.
- R6: Writing bit 2 of address 1 enables (1) or disables (0) the clock-loss detector. Read bit 2 is 1 only when the last reset came from clock loss, whatever the enable state.
- R7: With the detector enabled, a system clock that toggles at least every TIMEOUT_CYCLES causes no reset. When the clock stops, sysRstN goes low on the (TIMEOUT_CYCLES+4)th reference edge after its last transition.
- R8: When the system clock toggles again after a clock-loss reset, sysRstN rises on the 11th reference edge after that transition.
- R9: Register writes are ignored while sysRstN is low.
- R10: Resets other than power-on keep the monitor enable, the comparator select and the detector enable unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Free-running reference clock |
| porN | input | 1 | Power-on reset, active low, asynchronous |
| extRstN | input | 1 | External reset pin level, active low |
| supplyOk | input | 1 | Comparator output, 1 when supply is above threshold |
| sysClk | input | 1 | Monitored system clock |
| regAddr | input | 1 | Register select: 0 monitor, 1 cause |
| regWrEn | input | 1 | Write strobe, sampled on refClk |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for regAddr, combinational |
| sysRstN | output | 1 | System reset, active low, registered |

## Verification
Each result has a fixed latency in reference cycles. A pin or supply event reaches sysRstN three edges later, and release follows STRETCH_CYCLES+2 edges after the cause clears. A stopped system clock is reported TIMEOUT_CYCLES+4 edges after its last transition, and recovery follows 11 edges after the next transition. Register writes are visible one edge later. The bench records every expected sysRstN value together with the cycle it is due in. It checks both the due cycle and the cycle before, so an off-by-one in any stage shows up as a miscompare. Register contents are read on the falling edge, after each reset has been released.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

  localparam int REG_W = 8;

  // register addresses
  localparam logic ADDR_MON = 1'b0;
  localparam logic ADDR_SRC = 1'b1;

  // monitor register bit positions
  localparam int MON_EN_BIT   = 7;
  localparam int MON_STAT_BIT = 6;

  // cause register bit positions
  localparam int SRC_PIN_BIT = 0;
  localparam int SRC_POR_BIT = 1;
  localparam int SRC_CLK_BIT = 2;
  localparam int SRC_SEL_BIT = 3;
  localparam int SRC_SUP_BIT = 4;

  // strobes from control to datapath
  typedef struct packed {
    logic loadStretch;
    logic setPin;
    logic setSup;
    logic setClk;
    logic wrMon;
    logic wrSrc;
  } rscStrobe_t;

endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             arstN,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage1Q;
  logic [WIDTH-1:0] stage2Q;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      stage1Q <= RESET_VAL;
      stage2Q <= RESET_VAL;
    end else begin
      stage1Q <= d;
      stage2Q <= stage1Q;
    end
  end

  assign q = stage2Q;

endmodule

// File: rtl/rsc_clkmon.sv
module rsc_clkmon #(
  parameter int TIMEOUT_CYCLES = 16
) (
  input  logic refClk,
  input  logic porN,
  input  logic sysClk,
  input  logic enable,
  output logic clkLost
);

  localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(TIMEOUT_CYCLES);

  logic sysClkSync;
  logic sysClkPrevQ;
  logic edgeSeen;
  logic [CW-1:0] idleCntQ;

  rsc_sync #(.WIDTH(1), .RESET_VAL(1'b0)) u_sync (
    .clk  (refClk),
    .arstN(porN),
    .d    (sysClk),
    .q    (sysClkSync)
  );

  assign edgeSeen = sysClkSync ^ sysClkPrevQ;

  always_ff @(posedge refClk or negedge porN) begin
    if (!porN) begin
      sysClkPrevQ <= 1'b0;
      idleCntQ    <= '0;
    end else begin
      sysClkPrevQ <= sysClkSync;
      if (edgeSeen || !enable) begin
        idleCntQ <= '0;
      end else if (idleCntQ != LIMIT) begin
        idleCntQ <= idleCntQ + 1'b1;
      end
    end
  end

  assign clkLost = enable && (idleCntQ == LIMIT);

  AST_IDLE_BOUND: assert property (@(posedge refClk) disable iff (!porN)
    idleCntQ <= LIMIT) else $error("idle counter passed its limit"); // R7

  AST_EDGE_CLEARS: assert property (@(posedge refClk) disable iff (!porN)
    edgeSeen |=> !clkLost) else $error("loss flagged right after an edge"); // R8

endmodule

// File: rtl/rsc_ctrl.sv
module rsc_ctrl
  import rsc_pkg::*;
(
  input  logic       refClk,
  input  logic       porN,
  input  logic       pinLow,
  input  logic       supLow,
  input  logic       clkLost,
  input  logic       monEn,
  input  logic       monSel,
  input  logic       sysRstN,
  input  logic       regAddr,
  input  logic       regWrEn,
  output rscStrobe_t strobe
);

  logic supCause;
  logic anyCause;
  logic wrOpen;

  assign supCause = supLow && monEn && monSel;
  assign anyCause = pinLow || supCause || clkLost;
  assign wrOpen   = regWrEn && sysRstN;

  always_comb begin
    strobe             = '0;
    strobe.loadStretch = anyCause;
    // fixed priority: pin, then supply, then clock loss
    strobe.setPin      = pinLow;
    strobe.setSup      = supCause && !pinLow;
    strobe.setClk      = clkLost && !pinLow && !supCause;
    strobe.wrMon       = wrOpen && (regAddr == ADDR_MON);
    strobe.wrSrc       = wrOpen && (regAddr == ADDR_SRC);
  end

  AST_CAUSE_RESETS: assert property (@(posedge refClk) disable iff (!porN)
    (pinLow || clkLost) |=> !sysRstN) else $error("cause did not reset"); // R4

  AST_ONE_SETTER: assert property (@(posedge refClk) disable iff (!porN)
    $onehot0({strobe.setPin, strobe.setSup, strobe.setClk})) else $error("two causes recorded"); // R5

endmodule

// File: rtl/rsc_datapath.sv
module rsc_datapath
  import rsc_pkg::*;
#(
  parameter int STRETCH_CYCLES = 8
) (
  input  logic             refClk,
  input  logic             porN,
  input  rscStrobe_t       strobe,
  input  logic             regAddr,
  input  logic [REG_W-1:0] wrData,
  input  logic             supOk,
  output logic             monEn,
  output logic             monSel,
  output logic             clkEn,
  output logic [REG_W-1:0] rdData,
  output logic             sysRstN
);

  localparam int SW = $clog2(STRETCH_CYCLES + 1);
  localparam logic [SW-1:0] STRETCH_LOAD = SW'(STRETCH_CYCLES);

  logic          monEnQ;
  logic          monSelQ;
  logic          clkEnQ;
  logic          pinFlagQ;
  logic          porFlagQ;
  logic          clkFlagQ;
  logic          supFlagQ;
  logic [SW-1:0] stretchQ;
  logic [SW-1:0] stretchNext;
  logic          sysRstNQ;
  logic [REG_W-1:0] monView;
  logic [REG_W-1:0] srcView;

  always_comb begin
    if (strobe.loadStretch) begin
      stretchNext = STRETCH_LOAD;
    end else if (stretchQ != '0) begin
      stretchNext = stretchQ - 1'b1;
    end else begin
      stretchNext = '0;
    end
  end

  always_ff @(posedge refClk or negedge porN) begin
    if (!porN) begin
      stretchQ <= STRETCH_LOAD;
      sysRstNQ <= 1'b0;
    end else begin
      stretchQ <= stretchNext;
      sysRstNQ <= (stretchNext == '0);
    end
  end

  always_ff @(posedge refClk or negedge porN) begin
    if (!porN) begin
      pinFlagQ <= 1'b0;
      porFlagQ <= 1'b1;
      clkFlagQ <= 1'b0;
      supFlagQ <= 1'b0;
    end else if (strobe.setPin || strobe.setSup || strobe.setClk) begin
      pinFlagQ <= strobe.setPin;
      porFlagQ <= 1'b0;
      clkFlagQ <= strobe.setClk;
      supFlagQ <= strobe.setSup;
    end
  end

  always_ff @(posedge refClk or negedge porN) begin
    if (!porN) begin
      monEnQ  <= 1'b1;
      monSelQ <= 1'b1;
      clkEnQ  <= 1'b0;
    end else begin
      if (strobe.wrMon) begin
        monEnQ <= wrData[MON_EN_BIT];
      end
      if (strobe.wrSrc) begin
        clkEnQ  <= wrData[SRC_CLK_BIT];
        monSelQ <= wrData[SRC_SEL_BIT];
      end
    end
  end

  always_comb begin
    monView               = '0;
    monView[MON_EN_BIT]   = monEnQ;
    monView[MON_STAT_BIT] = supOk;
    srcView               = '0;
    srcView[SRC_PIN_BIT]  = pinFlagQ;
    srcView[SRC_POR_BIT]  = porFlagQ;
    srcView[SRC_CLK_BIT]  = clkFlagQ;
    srcView[SRC_SEL_BIT]  = monSelQ;
    srcView[SRC_SUP_BIT]  = supFlagQ;
  end

  assign rdData  = (regAddr == ADDR_MON) ? monView : srcView;
  assign monEn   = monEnQ;
  assign monSel  = monSelQ;
  assign clkEn   = clkEnQ;
  assign sysRstN = sysRstNQ;

  AST_ONE_FLAG: assert property (@(posedge refClk) disable iff (!porN)
    $onehot({pinFlagQ, porFlagQ, clkFlagQ, supFlagQ})) else $error("cause flags not one-hot"); // R5

  AST_SUP_GATED: assert property (@(posedge refClk) disable iff (!porN)
    strobe.setSup |-> (monEnQ && monSelQ)) else $error("supply reset while not armed"); // R3

  AST_WRITE_LOCK: assert property (@(posedge refClk) disable iff (!porN)
    !sysRstNQ |=> ($stable(monEnQ) && $stable(monSelQ) && $stable(clkEnQ)))
    else $error("control changed during reset"); // R9

  AST_RO_BITS: assert property (@(posedge refClk) disable iff (!porN)
    (strobe.wrMon && (wrData[MON_STAT_BIT:0] != '0)) |=>
      ((regAddr != ADDR_MON) || (rdData[MON_STAT_BIT-1:0] == '0)))
    else $error("unused monitor bits took a write"); // R2

  AST_STRETCH_HOLD: assert property (@(posedge refClk) disable iff (!porN)
    strobe.loadStretch |=> (!sysRstNQ && (stretchQ == STRETCH_LOAD)))
    else $error("stretch not reloaded"); // R4

endmodule

// File: rtl/reset_src_ctrl.sv
module reset_src_ctrl
  import rsc_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 16,
  parameter int STRETCH_CYCLES = 8
) (
  input  logic             refClk,
  input  logic             porN,
  input  logic             extRstN,
  input  logic             supplyOk,
  input  logic             sysClk,
  input  logic             regAddr,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic             sysRstN
);

  logic [1:0] padSync;
  logic       clkLost;
  logic       monEn;
  logic       monSel;
  logic       clkEn;
  rscStrobe_t strobe;

  rsc_sync #(.WIDTH(2), .RESET_VAL(2'b11)) u_padSync (
    .clk  (refClk),
    .arstN(porN),
    .d    ({extRstN, supplyOk}),
    .q    (padSync)
  );

  rsc_clkmon #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_clkmon (
    .refClk (refClk),
    .porN   (porN),
    .sysClk (sysClk),
    .enable (clkEn),
    .clkLost(clkLost)
  );

  rsc_ctrl u_ctrl (
    .refClk (refClk),
    .porN   (porN),
    .pinLow (!padSync[1]),
    .supLow (!padSync[0]),
    .clkLost(clkLost),
    .monEn  (monEn),
    .monSel (monSel),
    .sysRstN(sysRstN),
    .regAddr(regAddr),
    .regWrEn(regWrEn),
    .strobe (strobe)
  );

  rsc_datapath #(.STRETCH_CYCLES(STRETCH_CYCLES)) u_dp (
    .refClk (refClk),
    .porN   (porN),
    .strobe (strobe),
    .regAddr(regAddr),
    .wrData (regWrData),
    .supOk  (padSync[0]),
    .monEn  (monEn),
    .monSel (monSel),
    .clkEn  (clkEn),
    .rdData (regRdData),
    .sysRstN(sysRstN)
  );

endmodule

// File: tb/sim_reset_src_ctrl.sv
module sim_reset_src_ctrl;

  localparam int TIMEOUT = 16;
  localparam int STRETCH = 8;

  logic       refClk = 1'b0;
  logic       porN = 1'b0;
  logic       extRstN = 1'b1;
  logic       supplyOk = 1'b1;
  logic       sysClk = 1'b0;
  logic       regAddr = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       sysRstN;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  typedef struct {
    int    due;
    logic  exp;
    string tag;
  } sbItem_t;

  sbItem_t sb[$];

  reset_src_ctrl #(.TIMEOUT_CYCLES(TIMEOUT), .STRETCH_CYCLES(STRETCH)) u0 (
    .refClk(refClk), .porN(porN), .extRstN(extRstN), .supplyOk(supplyOk),
    .sysClk(sysClk), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .regRdData(regRdData), .sysRstN(sysRstN)
  );

  always #10 refClk = ~refClk;

  always @(posedge refClk) cyc <= cyc + 1;

  // monitor: pops items whose cycle has come and compares sysRstN
  always @(negedge refClk) begin
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      sbItem_t it;
      it = sb.pop_front();
      nChecks++;
      if (sysRstN !== it.exp) begin
        nFails++;
        $display("FAIL %s: sysRstN at cycle %0d is %b, expected %b", it.tag, cyc, sysRstN, it.exp);
      end
    end
  end

  task automatic expectRst(input int offset, input logic exp, input string tag);
    sbItem_t it;
    it.due = cyc + offset;
    it.exp = exp;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge refClk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge refClk);
  endtask

  task automatic checkNow(input logic exp, input string tag);
    nChecks++;
    if (sysRstN !== exp) begin
      nFails++;
      $display("FAIL %s: sysRstN is %b, expected %b", tag, sysRstN, exp);
    end
  endtask

  task automatic writeReg(input logic addr, input logic [7:0] data);
    @(negedge refClk);
    regAddr = addr;
    regWrData = data;
    regWrEn = 1'b1;
    @(negedge refClk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic addr, input logic [7:0] exp, input string tag);
    @(negedge refClk);
    regAddr = addr;
    #1;
    nChecks++;
    if (regRdData !== exp) begin
      nFails++;
      $display("FAIL %s: reg[%0d] is %h, expected %h", tag, addr, regRdData, exp);
    end
  endtask

  task automatic toggleSys(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge refClk);
      sysClk = ~sysClk;
      @(negedge refClk);
    end
  endtask

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge refClk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    // R1: reset state while power-on is held low
    idle(3);
    checkNow(1'b0, "R1 held in power-on");
    @(negedge refClk);
    porN = 1'b1;
    expectRst(STRETCH - 1, 1'b0, "R1 stretch");
    expectRst(STRETCH, 1'b1, "R1 release");
    drain();
    readReg(1'b1, 8'h0A, "R1 cause reg after power-on");
    readReg(1'b0, 8'hC0, "R1 R2 monitor reg after power-on");

    // R2: unused and status bits ignore writes; status is live
    writeReg(1'b0, 8'h7F);
    readReg(1'b0, 8'h40, "R2 enable cleared, low bits read 0");
    @(negedge refClk);
    supplyOk = 1'b0;
    idle(3);
    readReg(1'b0, 8'h00, "R2 live status low");
    checkNow(1'b1, "R3 disabled monitor gives no reset");
    @(negedge refClk);
    supplyOk = 1'b1;
    idle(3);
    writeReg(1'b0, 8'h80);
    readReg(1'b0, 8'hC0, "R2 enable set again");

    // R3: enabled but not selected gives no reset
    writeReg(1'b1, 8'h00);
    @(negedge refClk);
    supplyOk = 1'b0;
    idle(6);
    checkNow(1'b1, "R3 unselected monitor gives no reset");
    @(negedge refClk);
    supplyOk = 1'b1;
    idle(3);
    writeReg(1'b1, 8'h08);
    readReg(1'b1, 8'h0A, "R3 select written back");

    // R3: armed supply reset
    @(negedge refClk);
    supplyOk = 1'b0;
    expectRst(2, 1'b1, "R3 before assert");
    expectRst(3, 1'b0, "R3 assert");
    drain();
    idle(4);
    @(negedge refClk);
    supplyOk = 1'b1;
    expectRst(STRETCH + 1, 1'b0, "R3 stretch");
    expectRst(STRETCH + 2, 1'b1, "R3 release");
    drain();
    readReg(1'b1, 8'h18, "R3 R5 supply flag only");
    readReg(1'b0, 8'hC0, "R10 enable kept after supply reset");

    // R4 with R9: pin reset, writes during reset ignored
    @(negedge refClk);
    extRstN = 1'b0;
    expectRst(2, 1'b1, "R4 before assert");
    expectRst(3, 1'b0, "R4 assert");
    drain();
    writeReg(1'b0, 8'h00);
    writeReg(1'b1, 8'h04);
    @(negedge refClk);
    extRstN = 1'b1;
    expectRst(STRETCH + 1, 1'b0, "R4 stretch");
    expectRst(STRETCH + 2, 1'b1, "R4 release");
    drain();
    readReg(1'b1, 8'h09, "R4 R9 pin flag, select kept, no enable");
    readReg(1'b0, 8'hC0, "R9 monitor write ignored in reset");

    // R5: coincident pin and supply resets record the pin
    @(negedge refClk);
    writeReg(1'b1, 8'h08);
    @(negedge refClk);
    supplyOk = 1'b0;
    extRstN = 1'b0;
    idle(6);
    @(negedge refClk);
    supplyOk = 1'b1;
    extRstN = 1'b1;
    idle(STRETCH + 6);
    readReg(1'b1, 8'h09, "R5 pin wins over supply");

    // R6: enabling the detector does not set its flag
    writeReg(1'b1, 8'h0C);
    readReg(1'b1, 8'h09, "R6 enable bit reads flag not enable");

    // R7: a running system clock gives no reset
    toggleSys(30);
    checkNow(1'b1, "R7 running clock no reset");
    expectRst(TIMEOUT + 2, 1'b1, "R7 before loss");
    expectRst(TIMEOUT + 3, 1'b0, "R7 loss detected");
    drain();
    idle(10);
    checkNow(1'b0, "R7 held while clock stopped");
    readReg(1'b1, 8'h0C, "R6 R5 clock-loss flag only");

    // R8: recovery
    @(negedge refClk);
    sysClk = ~sysClk;
    expectRst(STRETCH + 2, 1'b0, "R8 stretch");
    expectRst(STRETCH + 3, 1'b1, "R8 release");
    toggleSys(12);
    drain();
    readReg(1'b1, 8'h0C, "R10 detector enable kept");

    // R6: disabled detector ignores a stopped clock
    writeReg(1'b1, 8'h08);
    idle(TIMEOUT * 3);
    checkNow(1'b1, "R6 disabled detector no reset");
    readReg(1'b1, 8'h0C, "R6 flag persists, detector off");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule